// File: doc/BRIEF.md
# Master Transfer Handshake Sequencer

This block sits in a serial master beside the byte-wide shift port. It runs one exchange, or a run of exchanges, with one of several slaves. It uses two sideband lines per slave: a request output that interrupts the slave and a ready input the slave raises when it is set up. The sequence has four phases. The sequencer raises request and waits for that slave's ready. It drops request and loads the transmit byte into the shift port with an exchange access. It waits for the port's completion flag. Finally it waits for the slave to drop ready before it will take the next transaction. The exchange access also returns what the port held, which is the byte received in the previous transfer.

Transmit bytes arrive on a valid/ready stream (`tx_valid`, `tx_ready`, `tx_data`, `tx_last`). A beat offered while idle starts a transaction. The beat must then hold `tx_valid`, `tx_data`, `tx_last` and `slave_sel` stable until `tx_ready` is high, because `tx_ready` is asserted only in the cycle the byte goes to the port. A beat whose `tx_last` is 0 asks for a burst. The next beat is then sent in the same cycle the completion flag rises, which keeps the serial clock nearly unbroken. Received bytes leave on `rx_valid`/`rx_data` with no back-pressure: `rx_valid` is a one-cycle pulse and the consumer must take it.

The shift port is expected to clear `shift_done` from the clock edge that takes `xchg_strobe`, and to raise it again when eight bits have moved. Ready inputs are asynchronous and go through a two-flop synchronizer.

Top module: `xfer_handshake_seq`

## Requirements
- R1: While reset is held low and after it is released, `busy`, `tx_ready`, `xchg_strobe` and `rx_valid` are 0 and all `req_o` bits are 0.
- R2: With `busy` low, `tx_valid` high starts a transaction. From the next cycle `busy` is 1 and `req_o` is one-hot at bit index `slave_sel`, the index captured at the start.
- R3: Request stays high until the selected ready input, after two synchronizer flops, reads 1. A ready rise applied between edges removes request on the third following edge. The exchange strobe is asserted in that same cycle, the first one with request low.
- R4: In each exchange cycle, `xchg_strobe` and `tx_ready` are both high for exactly that cycle and `xchg_wdata` equals `tx_data`.
- R5: After an exchange, no further exchange occurs and the transaction does not move on until `shift_done` reads 1.
- R6: After the completion of the beat marked `tx_last`=1, `busy` stays high while the selected ready stays high. A ready fall applied between edges drops `busy` on the third following edge.
- R7: Only the selected slave is served. Ready inputs of other slaves and changes to `slave_sel` during a transaction have no effect on `req_o` or on the exchange. At most one `req_o` bit is ever high.
- R8: Burst: when the last beat sent had `tx_last`=0 and `tx_valid` is high, the next exchange occurs in the first cycle `shift_done` reads 1. If `tx_valid` is low then, the sequencer waits with no exchange, and exchanges in the cycle `tx_valid` returns.
- R9: One cycle after each exchange, `rx_valid` pulses for a single cycle. `rx_data` then carries `xchg_rdata` as it was in the exchange cycle, which is the byte received by the previous transfer.
- R10: A beat offered while `busy` is high outside an exchange cycle is not accepted (`tx_ready` stays 0) and does not raise any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit beat offered |
| tx_ready | output | 1 | Transmit beat taken this cycle |
| tx_data | input | DATA_W | Transmit byte |
| tx_last | input | 1 | 1 = final beat of the transaction, 0 = burst continues |
| slave_sel | input | SEL_W | Index of the target slave, captured at start |
| busy | output | 1 | Transaction in progress |
| rx_valid | output | 1 | One-cycle pulse, received byte valid |
| rx_data | output | DATA_W | Byte received by the previous transfer |
| req_o | output | NUM_SLAVES | Per-slave request (interrupt) lines |
| rdy_i | input | NUM_SLAVES | Per-slave ready lines, asynchronous |
| xchg_strobe | output | 1 | Exchange access to the shift port |
| xchg_wdata | output | DATA_W | Byte written by the exchange access |
| xchg_rdata | input | DATA_W | Current shift port contents |
| shift_done | input | 1 | Shift port completion flag |

## Verification
A wrong phase shows up within a few cycles. A sequencer stuck in the request phase keeps `req_o` high three edges after ready rose. One that skips the completion wait issues a second strobe before `shift_done`. One that skips the release wait drops `busy` while ready is still high. A wrong captured slave index lights the wrong `req_o` bit one cycle after start. A wrong last-beat flag either ends a burst early, with `busy` falling and beats stranded, or waits for a beat that never comes. A slip in the receive path appears at the next `rx_valid` pulse as a byte from the wrong transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_XCHG    = 3'd2,
    ST_SHIFT   = 3'd3,
    ST_RELEASE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/hs_lines.sv
module hs_lines #(
  parameter int NUM_SLAVES = 4,
  parameter int SEL_W      = 2
) (
  input  logic                  req_en,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NUM_SLAVES-1:0] rdy_sync,
  output logic [NUM_SLAVES-1:0] req_o,
  output logic                  rdy_sel
);
  logic [NUM_SLAVES-1:0] hit;

  for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_slave
    assign hit[g]   = (sel == SEL_W'(g));
    assign req_o[g] = req_en & hit[g];
  end

  assign rdy_sel = |(rdy_sync & hit);
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_last,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              rdy_sel,
  input  logic              shift_done,
  input  logic [DATA_W-1:0] xchg_rdata,
  output logic              tx_ready,
  output logic              req_en,
  output logic [SEL_W-1:0]  sel_q,
  output logic              busy,
  output logic              xchg_strobe,
  output logic [DATA_W-1:0] xchg_wdata,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  seq_state_e st, st_nx;
  logic       last_q;
  logic       go;

  // exchange in the load cycle, or chained in a burst on completion
  always_comb begin
    go = (st == ST_XCHG) ||
         (st == ST_SHIFT && shift_done && !last_q && tx_valid);
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (tx_valid)               st_nx = ST_REQ;
      ST_REQ:     if (rdy_sel)                st_nx = ST_XCHG;
      ST_XCHG:                                st_nx = ST_SHIFT;
      ST_SHIFT:   if (shift_done && last_q)   st_nx = ST_RELEASE;
      ST_RELEASE: if (!rdy_sel)               st_nx = ST_IDLE;
      default:                                st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      last_q   <= 1'b1;
      sel_q    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      st       <= st_nx;
      rx_valid <= go;
      if (st == ST_IDLE && tx_valid) sel_q <= sel_in;
      if (go) begin
        last_q  <= tx_last;
        rx_data <= xchg_rdata;
      end
    end
  end

  assign tx_ready    = go;
  assign xchg_strobe = go;
  assign xchg_wdata  = tx_data;
  assign req_en      = (st == ST_REQ);
  assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/xfer_handshake_seq.sv
module xfer_handshake_seq #(
  parameter int NUM_SLAVES  = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [DATA_W-1:0]     tx_data,
  input  logic                  tx_last,
  input  logic [SEL_W-1:0]      slave_sel,
  output logic                  busy,
  output logic                  rx_valid,
  output logic [DATA_W-1:0]     rx_data,
  output logic [NUM_SLAVES-1:0] req_o,
  input  logic [NUM_SLAVES-1:0] rdy_i,
  output logic                  xchg_strobe,
  output logic [DATA_W-1:0]     xchg_wdata,
  input  logic [DATA_W-1:0]     xchg_rdata,
  input  logic                  shift_done
);
  logic [NUM_SLAVES-1:0] rdy_s;
  logic                  rdy_sel;
  logic                  req_en;
  logic [SEL_W-1:0]      sel_q;

  hs_sync #(.WIDTH(NUM_SLAVES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rdy_i), .q_sync(rdy_s)
  );

  hs_lines #(.NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) u_lines (
    .req_en(req_en), .sel(sel_q), .rdy_sync(rdy_s),
    .req_o(req_o), .rdy_sel(rdy_sel)
  );

  hs_fsm #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .sel_in(slave_sel), .rdy_sel(rdy_sel), .shift_done(shift_done),
    .xchg_rdata(xchg_rdata), .tx_ready(tx_ready), .req_en(req_en),
    .sel_q(sel_q), .busy(busy), .xchg_strobe(xchg_strobe),
    .xchg_wdata(xchg_wdata), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk #(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tx_valid,
  input logic                  tx_ready,
  input logic                  busy,
  input logic                  rx_valid,
  input logic [DATA_W-1:0]     rx_data,
  input logic [NUM_SLAVES-1:0] req_o,
  input logic                  xchg_strobe,
  input logic [DATA_W-1:0]     xchg_rdata,
  input logic                  shift_done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (req_o == '0 && !xchg_strobe && !tx_ready)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_valid) |=> busy); // R2
  AST_REQ_LOW_AT_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_strobe |-> (req_o == '0)); // R3
  AST_XCHG_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_strobe |-> (tx_valid && busy)); // R4
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_o)); // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_o && |$past(req_o)) |-> $stable(req_o)); // R7
  AST_RX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_strobe |=> (rx_valid && rx_data == $past(xchg_rdata))); // R9
  AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(xchg_strobe)); // R9
  AST_DONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_strobe && $past(xchg_strobe)) |-> 1'b0 || !$past(xchg_strobe)); // R5
endmodule

bind xfer_handshake_seq hs_seq_chk #(.NUM_SLAVES(NUM_SLAVES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data), .req_o(req_o),
  .xchg_strobe(xchg_strobe), .xchg_rdata(xchg_rdata), .shift_done(shift_done)
);

// File: tb/xfer_handshake_seq_bench.sv
module xfer_handshake_seq_bench;
  localparam int NS = 4;
  localparam int DW = 8;
  localparam int SW = 2;
  localparam int SHIFT_CYC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          tx_last = 1'b1;
  logic [SW-1:0] slave_sel = '0;
  logic          busy;
  logic          rx_valid;
  logic [DW-1:0] rx_data;
  logic [NS-1:0] req_o;
  logic [NS-1:0] rdy_i = '0;
  logic          xchg_strobe;
  logic [DW-1:0] xchg_wdata;
  logic [DW-1:0] port_reg;
  logic          shift_done;
  int            sh_cnt;
  logic          done_prev;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] port_model = '0;
  logic          rxv_prev = 1'b0;

  always #4 clk = ~clk;

  xfer_handshake_seq #(.NUM_SLAVES(NS), .DATA_W(DW)) u_xfer_handshake_seq (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .slave_sel(slave_sel),
    .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data), .req_o(req_o),
    .rdy_i(rdy_i), .xchg_strobe(xchg_strobe), .xchg_wdata(xchg_wdata),
    .xchg_rdata(port_reg), .shift_done(shift_done)
  );

  // shift port model: slave returns the written byte xor 5A on the next exchange
  always @(posedge clk) begin
    done_prev <= shift_done;
    if (!rst_n) begin
      port_reg <= '0; shift_done <= 1'b1; sh_cnt <= 0;
    end else if (xchg_strobe) begin
      port_reg <= xchg_wdata ^ 8'h5A; shift_done <= 1'b0; sh_cnt <= SHIFT_CYC;
    end else if (sh_cnt > 0) begin
      sh_cnt <= sh_cnt - 1;
      if (sh_cnt == 1) shift_done <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected received bytes
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected rx", 32'(rx_data), 32'hFFFF);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R9 rx_data", 32'(rx_data), 32'(e));
        end
        chk(!rxv_prev, "R9 pulse width", 32'(rxv_prev), 32'd0);
      end
      rxv_prev <= rx_valid;
    end
  end

  task automatic note_xchg();
    exp_q.push_back(port_model);
    port_model = xchg_wdata ^ 8'h5A;
  endtask

  task automatic wait_strobe(input string req);
    int guard = 0;
    do begin
      @(negedge clk);
      if (!xchg_strobe) chk(1'b1, req, 0, 0);
      guard++;
    end while (!xchg_strobe && guard < 100);
    if (guard >= 100) chk(1'b0, {req, " no strobe"}, 0, 1);
  endtask

  task automatic run_txn(input int sel, input int nbytes, input logic [DW-1:0] base, input int stall_beat);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = base; tx_last = (nbytes == 1); slave_sel = SW'(sel);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy", 32'(busy), 1);
    chk(req_o == NS'(1 << sel), "R2 req one-hot", 32'(req_o), 32'(1 << sel));
    // other slaves ready and a changed select: no effect
    rdy_i = ~NS'(1 << sel);
    slave_sel = SW'(sel + 1);
    repeat (4) begin
      @(negedge clk);
      chk(req_o == NS'(1 << sel), "R7 req kept", 32'(req_o), 32'(1 << sel));
      chk(!xchg_strobe, "R7 no exchange", 32'(xchg_strobe), 0);
    end
    rdy_i = NS'(1 << sel);
    repeat (2) begin
      @(negedge clk);
      chk(req_o == NS'(1 << sel), "R3 req until synced", 32'(req_o), 32'(1 << sel));
    end
    @(negedge clk);
    chk(req_o == '0, "R3 req dropped", 32'(req_o), 0);
    chk(xchg_strobe && tx_ready, "R3 exchange", 32'(xchg_strobe), 1);
    chk(xchg_wdata == base, "R4 wdata", 32'(xchg_wdata), 32'(base));
    note_xchg();
    for (int k = 1; k < nbytes; k++) begin
      @(negedge clk);
      chk(!xchg_strobe, "R4 single cycle", 32'(xchg_strobe), 0);
      tx_data = base + DW'(k); tx_last = (k == nbytes - 1);
      if (k == stall_beat) begin
        tx_valid = 1'b0;
        while (!shift_done) @(negedge clk);
        repeat (3) begin
          @(negedge clk);
          chk(!xchg_strobe && busy, "R8 stall waits", 32'(xchg_strobe), 0);
        end
        tx_valid = 1'b1;
        #1;
        chk(xchg_strobe, "R8 resume", 32'(xchg_strobe), 1);
        @(negedge clk);
        chk(1'b1, "R8", 0, 0);
        // strobe occurred in the cycle before this negedge
        exp_q.push_back(port_model);
        port_model = (base + DW'(k)) ^ 8'h5A;
        continue;
      end
      wait_strobe("R5");
      chk(shift_done && !done_prev, "R8 chained on first done", 32'(done_prev), 0);
      chk(xchg_wdata == base + DW'(k), "R4 burst wdata", 32'(xchg_wdata), 32'(base + DW'(k)));
      note_xchg();
    end
    @(negedge clk);
    tx_valid = 1'b0;
    while (!shift_done) begin
      chk(!xchg_strobe, "R5 no early exchange", 32'(xchg_strobe), 0);
      @(negedge clk);
    end
    // ready still high: stays busy, new beats refused
    tx_valid = 1'b1; tx_data = 8'hEE; tx_last = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(busy, "R6 busy while ready", 32'(busy), 1);
      chk(!tx_ready && req_o == '0, "R10 beat refused", 32'(req_o), 0);
    end
    tx_valid = 1'b0;
    rdy_i = '0;
    repeat (2) begin
      @(negedge clk);
      chk(busy, "R6 busy sync delay", 32'(busy), 1);
    end
    @(negedge clk);
    chk(!busy, "R6 released", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && req_o == '0 && !tx_ready && !xchg_strobe && !rx_valid, "R1 in reset", 32'(req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_o == '0 && !rx_valid, "R1 after reset", 32'(busy), 0);
    run_txn(0, 1, 8'h3C, -1);
    run_txn(2, 1, 8'hA1, -1);
    run_txn(3, 3, 8'h10, -1);
    run_txn(1, 3, 8'h70, 1);
    run_txn(2, 2, 8'hC4, -1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all received", 32'(exp_q.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule